// File: doc/BRIEF.md
# Vertical Field/Frame Readout Sequencer

This block runs at line rate and steps an interlaced-readout image sensor through its vertical frames. It advances a line counter on every strobe from the line timing generator. From the counter it decides which lines carry the vertical sync pulse, the row-readout pulse, the charge-sweep burst and the overflow-drain shutter pulse. Pixel-level timing is left to the line timing generator, which uses these per-line flags.

There are two modes. The monitoring (field) mode uses a short frame split into two fields. Each field has one sync line, one subsampled readout line and one shutter line. The capture (frame) mode uses a longer frame. It alternates between an odd-row pass and an even-row pass. Each pass is preceded by a sweep burst that clears the vertical register, and the burst length depends on the pass. A mode request is taken up only when a frame wraps. The first frame after reset, and the first frame after each mode change, are marked as not usable.

Top module: `ccd_vseq`

## Requirements
- R1: After reset the block is in field mode on line 1. `vd` is 1, `data_valid` is 0, and `frame_mode`, `sweep_en`, `readout` and `shutter` are 0.
- R2: In field mode a frame lasts FIELD_LINES strobes. `vd` is 1 on line 1 and on line FIELD_HALF, and 0 on all other lines.
- R3: In frame mode a frame lasts FRAME_LINES strobes, and `vd` is 1 only on line 1.
- R4: In field mode `readout` is 1 on lines 1+READ_OFS and FIELD_HALF+READ_OFS, and `read_even` is 0.
- R5: In field mode `shutter` is 1 on lines 1+SHUT_OFS and FIELD_HALF+SHUT_OFS, so it fires once per field. In frame mode `shutter` is never 1.
- R6: In frame mode `sweep_en` is 1 only on line SWEEP_LINE and `readout` is 1 only on line SWEEP_LINE+1. `read_even` is 1 throughout an even-row pass.
- R7: While `sweep_en` is 1, `sweep_len` is SWEEP_LONG before an odd-row pass and SWEEP_SHORT before an even-row pass. At all other times `sweep_len` is 0.
- R8: The first frame-mode frame after entering frame mode is an odd-row pass. Consecutive frame-mode frames then alternate odd, even, odd, and so on.
- R9: `mode_req` is sampled only on the strobe that ends the last line of a frame. Changes at any other time have no effect, and `frame_mode` changes only when a frame starts (`vd` is 1).
- R10: `data_valid` is 0 for the whole first frame after reset and for the whole first frame after any mode change. It is 1 for every other frame and falls only on line 1.
- R11: All outputs change only on a clock edge on which `line_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle strobe marking the end of a line |
| mode_req | input | 1 | Requested mode: 0 field, 1 frame |
| vd | output | 1 | Vertical sync for the current line |
| readout | output | 1 | Current line carries the row-readout pulse |
| read_even | output | 1 | Current frame-mode pass reads even rows |
| sweep_en | output | 1 | Current line carries the charge-sweep burst |
| sweep_len | output | $clog2(SWEEP_LONG+1) | Number of vertical stages in the burst |
| shutter | output | 1 | Current line carries the overflow-drain shutter pulse |
| data_valid | output | 1 | Frame output is usable |
| frame_mode | output | 1 | Mode in force: 0 field, 1 frame |

## Verification
The hardest case to reach is a mode request that changes in the middle of a frame and changes back before the frame wraps. The bench toggles `mode_req` on an interior line and restores it before the last line. The sequence stays in its mode and `data_valid` stays high. The second hard case is re-entering frame mode after an excursion to field mode. Here the pass parity must restart at the odd pass with the long sweep. The stimulus therefore runs field, frame, field and frame again, using a small line count so that every line of every frame is compared.

// File: rtl/ccd_vseq.sv
module ccd_vseq #(
  parameter int FIELD_LINES = 525,
  parameter int FIELD_HALF  = 263,
  parameter int FRAME_LINES = 656,
  parameter int READ_OFS    = 2,
  parameter int SHUT_OFS    = 5,
  parameter int SWEEP_LINE  = 10,
  parameter int SWEEP_LONG  = 1368,
  parameter int SWEEP_SHORT = 684
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic mode_req,
  output logic vd,
  output logic readout,
  output logic read_even,
  output logic sweep_en,
  output logic [$clog2(SWEEP_LONG+1)-1:0] sweep_len,
  output logic shutter,
  output logic data_valid,
  output logic frame_mode
);
  localparam int MAXL = (FIELD_LINES > FRAME_LINES) ? FIELD_LINES : FRAME_LINES;
  localparam int LW   = $clog2(MAXL + 1);
  localparam int SLW  = $clog2(SWEEP_LONG + 1);
  localparam logic [LW-1:0] L_ONE  = LW'(1);
  localparam logic [LW-1:0] L_FEND = LW'(FIELD_LINES);
  localparam logic [LW-1:0] L_FREN = LW'(FRAME_LINES);
  localparam logic [LW-1:0] L_HALF = LW'(FIELD_HALF);
  localparam logic [LW-1:0] L_RD0  = LW'(1 + READ_OFS);
  localparam logic [LW-1:0] L_RD1  = LW'(FIELD_HALF + READ_OFS);
  localparam logic [LW-1:0] L_SH0  = LW'(1 + SHUT_OFS);
  localparam logic [LW-1:0] L_SH1  = LW'(FIELD_HALF + SHUT_OFS);
  localparam logic [LW-1:0] L_SW   = LW'(SWEEP_LINE);
  localparam logic [LW-1:0] L_FRD  = LW'(SWEEP_LINE + 1);

  logic [LW-1:0] line;
  logic          pass;
  logic          fresh;
  logic          wrap;

  assign wrap = line == (frame_mode ? L_FREN : L_FEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line       <= L_ONE;
      frame_mode <= 1'b0;
      pass       <= 1'b0;
      fresh      <= 1'b1;
    end else if (line_stb) begin
      if (wrap) begin
        line <= L_ONE;
        if (mode_req != frame_mode) begin
          frame_mode <= mode_req;
          fresh      <= 1'b1;
          pass       <= 1'b0;
        end else begin
          fresh <= 1'b0;
          pass  <= frame_mode & ~pass;
        end
      end else begin
        line <= line + L_ONE;
      end
    end
  end

  assign vd         = (line == L_ONE) | (~frame_mode & (line == L_HALF));
  assign readout    = frame_mode ? (line == L_FRD) : ((line == L_RD0) | (line == L_RD1));
  assign read_even  = frame_mode & pass;
  assign sweep_en   = frame_mode & (line == L_SW);
  assign sweep_len  = sweep_en ? (pass ? SLW'(SWEEP_SHORT) : SLW'(SWEEP_LONG)) : '0;
  assign shutter    = ~frame_mode & ((line == L_SH0) | (line == L_SH1));
  assign data_valid = ~fresh;
endmodule

// File: rtl/ccd_vseq_chk.sv
module ccd_vseq_chk #(
  parameter int SLW   = 11,
  parameter int LONG  = 1368,
  parameter int SHORT = 684
) (
  input logic clk,
  input logic rst_n,
  input logic line_stb,
  input logic vd,
  input logic readout,
  input logic read_even,
  input logic sweep_en,
  input logic [SLW-1:0] sweep_len,
  input logic shutter,
  input logic data_valid,
  input logic frame_mode
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable({vd, readout, read_even, sweep_en, sweep_len, shutter, data_valid, frame_mode}));

  assert_sweep_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_en |-> frame_mode && !readout);

  assert_shutter_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shutter |-> !frame_mode);

  assert_sweep_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_en |-> (sweep_len == SLW'(LONG)) || (sweep_len == SLW'(SHORT)));

  assert_sweep_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_en |-> sweep_len == '0);

  assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({readout, sweep_en, shutter}));

  assert_mode_at_vd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_mode) |-> vd);

  assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_valid) |-> vd);
endmodule

bind ccd_vseq ccd_vseq_chk #(
  .SLW($clog2(SWEEP_LONG+1)), .LONG(SWEEP_LONG), .SHORT(SWEEP_SHORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vd(vd), .readout(readout),
  .read_even(read_even), .sweep_en(sweep_en), .sweep_len(sweep_len),
  .shutter(shutter), .data_valid(data_valid), .frame_mode(frame_mode)
);

// File: tb/sim_ccd_vseq.sv
`timescale 1ns/1ps
module sim_ccd_vseq;
  localparam int FL = 12, FH = 7, FR = 15, RO = 1, SO = 3, SW = 2, LG = 40, SH = 20;
  localparam int SLW = $clog2(LG + 1);

  logic clk = 0, rst_n = 0, line_stb = 0, mode_req = 0;
  logic vd, readout, read_even, sweep_en, shutter, data_valid, frame_mode;
  logic [SLW-1:0] sweep_len;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mline = 1, mmode = 0, mpass = 0, mfresh = 1;

  always #5 clk = ~clk;

  ccd_vseq #(.FIELD_LINES(FL), .FIELD_HALF(FH), .FRAME_LINES(FR), .READ_OFS(RO),
             .SHUT_OFS(SO), .SWEEP_LINE(SW), .SWEEP_LONG(LG), .SWEEP_SHORT(SH)) u0 (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .mode_req(mode_req), .vd(vd),
    .readout(readout), .read_even(read_even), .sweep_en(sweep_en), .sweep_len(sweep_len),
    .shutter(shutter), .data_valid(data_valid), .frame_mode(frame_mode));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s line %0d: actual %0d expected %0d", tag, mline, act, exp);
    end
  endtask

  task automatic check_all();
    int e_vd, e_rd, e_sw, e_sh;
    e_vd = (mline == 1 || (mmode == 0 && mline == FH)) ? 1 : 0;
    e_rd = mmode ? (mline == SW + 1) : (mline == 1 + RO || mline == FH + RO);
    e_sw = (mmode && mline == SW) ? 1 : 0;
    e_sh = (!mmode && (mline == 1 + SO || mline == FH + SO)) ? 1 : 0;
    chk(mmode ? "R3 vd" : "R2 vd", vd, e_vd);
    chk(mmode ? "R6 readout" : "R4 readout", readout, e_rd);
    chk("R8 read_even", read_even, mmode && mpass);
    chk("R6 sweep_en", sweep_en, e_sw);
    chk("R7 sweep_len", sweep_len, e_sw ? (mpass ? SH : LG) : 0);
    chk("R5 shutter", shutter, e_sh);
    chk("R10 data_valid", data_valid, !mfresh);
    chk("R9 frame_mode", frame_mode, mmode);
  endtask

  task automatic step();
    @(negedge clk) line_stb = 1;
    @(negedge clk) line_stb = 0;
    if (mline == (mmode ? FR : FL)) begin
      mline = 1;
      if (int'(mode_req) != mmode) begin mmode = mode_req; mfresh = 1; mpass = 0; end
      else begin mfresh = 0; mpass = mmode ? !mpass : 0; end
    end else mline++;
    check_all();
    repeat (3) @(negedge clk);
    check_all();  // R11: held between strobes
  endtask

  task automatic run_frames(input int req, input int frames, input bit glitch);
    mode_req = req[0];
    for (int f = 0; f < frames; f++) begin
      int len;
      len = mmode ? FR : FL;
      for (int l = 0; l < len; l++) begin
        if (glitch && l == 4) mode_req = !req[0];
        if (glitch && l == 6) mode_req = req[0];
        step();
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 vd", vd, 1);
    chk("R1 data_valid", data_valid, 0);
    chk("R1 frame_mode", frame_mode, 0);
    chk("R1 sweep_en", sweep_en, 0);
    chk("R1 readout", readout, 0);
    chk("R1 shutter", shutter, 0);
    check_all();
    run_frames(0, 2, 1);
    run_frames(1, 4, 1);
    run_frames(0, 2, 0);
    run_frames(1, 3, 0);
    run_frames(0, 1, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule